// File: doc/BRIEF.md
# Serial Strobe-Framed Register Slave

This block is a small register slave driven by a host over four general-purpose lines: a serial clock, a serial data input, a serial data output and an active-low strobe. The host toggles these lines in software. Nothing marks the start of a frame. The slave records every bit the host clocks in. The one clock pulse taken while the strobe is low closes the frame. The data bit of that pulse selects the direction: 1 means write and 0 means read. The address and the write data are taken from the bits recorded before that pulse.

The register file has the following contents:
- a mode register and a multiplexer register, both read/write, each driven out of the block as a 32-bit output;
- a reset register, read/write, whose value drives a system reset request;
- a DIP switch bank, read-only, sampled from input pins;
- a version constant, read-only.

The serial lines are brought into the system clock domain through two-flop synchronizers. Their edges are then detected in that domain.

Top module: `ssr_slave`

## Requirements
- R1: Write frame. A write frame is sent most significant bit first as 32 data bits, then 8 address bits, then one strobed bit of value 1. Bits are taken on serial clock rising edges. A write frame to address 0x00 loads the mode register, and the new value appears on `mode_o`.
- R2: A write frame to address 0x02 loads the multiplexer register, and the new value appears on `mux_o`.
- R3: Read frame. A read frame is 8 address bits followed by one strobed bit of value 0. After it, the selected register is returned most significant bit first on `ser_sdo_o`. Bit 31 is driven before the first following rising edge. The output moves to the next bit after each following serial clock falling edge. The host reads 32 bits in total, one after each rising edge.
- R4: A read of 0x08 returns the `dip_i` bank zero-extended to 32 bits. A read of 0xFF returns the VERSION parameter.
- R5: A write to 0x80 loads the reset register, which reads back its stored value. `sys_rst_req_o` is 1 exactly while that register holds the value 1.
- R6: Writes to 0x08, to 0xFF and to unmapped addresses change no register. The mode, multiplexer and reset registers read back unchanged, and the DIP and version reads are unaffected.
- R7: A read of any unmapped address returns 0.
- R8: `ser_sdo_o` is 1 whenever no read data is being returned. This covers the idle state and the time after the falling edge that follows the 32nd returned bit.
- R9: Reset (`rst_n` low) clears the mode, multiplexer and reset registers to 0 and sets `ser_sdo_o` to 1.
- R10: Only the 40 bits clocked in immediately before the strobed bit form the frame. Any earlier bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_sck_i | input | 1 | Serial clock from the host |
| ser_sdi_i | input | 1 | Serial data from the host |
| ser_stb_n_i | input | 1 | Active-low frame strobe |
| ser_sdo_o | output | 1 | Serial read data; 1 when idle |
| dip_i | input | DIP_W | DIP switch bank |
| mode_o | output | 32 | Mode register value |
| mux_o | output | 32 | Multiplexer register value |
| sys_rst_req_o | output | 1 | System reset request |

## Verification
The bench runs a seeded random mix of reads and writes across the mapped and unmapped addresses, checks each one against a bench model, and adds directed cases.

The directed cases target these faults and the symptom each one would produce:
- **Early shift-out.** A slave that shifts out on the strobe pulse's own falling edge would lose bit 31. The bench samples the output right after the strobe and compares it with bit 31.
- **Wrong frame window.** A slave that keeps more than 40 bits, or takes the address from the wrong end of the recorded bits, would decode the wrong register. The bench sends junk bits before a frame to expose this.
- **Read-only or unmapped writes.** A slave that lets these through would corrupt the mode, multiplexer or reset register. The bench reads those registers back afterwards.
- **Output left driven.** A slave that keeps driving after the 32nd bit would leave a 0 on the line. The bench checks the line level after every read.
- **Reset request decode.** The bench writes values other than 1 to the reset register and checks that the request stays low.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int HIST_W = ADDR_W + DATA_W;

  localparam logic [ADDR_W-1:0] ADR_MODE    = 8'h00;
  localparam logic [ADDR_W-1:0] ADR_MUX     = 8'h02;
  localparam logic [ADDR_W-1:0] ADR_DIP     = 8'h08;
  localparam logic [ADDR_W-1:0] ADR_RESET   = 8'h80;
  localparam logic [ADDR_W-1:0] ADR_VERSION = 8'hFF;
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        sync_q <= RST_VAL[g];
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign q_o[g] = sync_q;
  end
endmodule

// File: rtl/ssr_frame.sv
module ssr_frame
  import ssr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              stb_n_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              sdo_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W - 1);

  logic              sck_q;
  logic              rise, fall, strobed, rd_ld;
  logic [HIST_W-1:0] hist_q, hist_d;
  logic [DATA_W-1:0] shr_q, shr_d;
  logic              act_q, act_d, arm_q, arm_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  assign rise    = sck_i & ~sck_q;
  assign fall    = ~sck_i & sck_q;
  assign strobed = rise & ~stb_n_i;
  assign wr_en_o = strobed & sdi_i;
  assign rd_ld   = strobed & ~sdi_i;

  assign addr_o    = hist_q[ADDR_W-1:0];
  assign wr_data_o = hist_q[HIST_W-1:ADDR_W];
  assign sdo_o     = act_q ? shr_q[DATA_W-1] : 1'b1;

  always_comb begin
    hist_d = hist_q;
    if (rise && stb_n_i) hist_d = {hist_q[HIST_W-2:0], sdi_i};
  end

  always_comb begin
    shr_d = shr_q;
    act_d = act_q;
    arm_d = arm_q;
    cnt_d = cnt_q;
    if (rd_ld) begin
      shr_d = rd_data_i;
      act_d = 1'b1;
      arm_d = 1'b0;
      cnt_d = '0;
    end else if (fall && act_q) begin
      if (!arm_q) begin
        arm_d = 1'b1;
      end else if (cnt_q == LAST_CNT) begin
        act_d = 1'b0;
      end else begin
        shr_d = {shr_q[DATA_W-2:0], 1'b0};
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      hist_q <= '0;
      shr_q  <= '0;
      act_q  <= 1'b0;
      arm_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sck_q  <= sck_i;
      hist_q <= hist_d;
      shr_q  <= shr_d;
      act_q  <= act_d;
      arm_q  <= arm_d;
      cnt_q  <= cnt_d;
    end
  end

  // R3: a read load presents bit 31 of the selected register next cycle
  assert_load_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ld |=> (sdo_o == $past(rd_data_i[DATA_W-1])));

  // R8: the output line moves only on a load or a serial falling edge
  assert_sdo_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_o) |-> $past(rd_ld || fall));

  // R10: the strobed bit is not taken into the shift history
  assert_hist_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strobed |=> $stable(hist_q));
endmodule

// File: rtl/ssr_regs.sv
module ssr_regs
  import ssr_pkg::*;
#(
  parameter int                DIP_W   = 8,
  parameter logic [DATA_W-1:0] VERSION = 32'h0000_0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DIP_W-1:0]  dip_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] mux_o,
  output logic              rst_req_o
);
  logic [DATA_W-1:0] mode_q, mode_d, mux_q, mux_d, rst_q, rst_d;
  logic              req_q, req_d;

  always_comb begin
    mode_d = mode_q;
    mux_d  = mux_q;
    rst_d  = rst_q;
    if (wr_en_i) begin
      case (addr_i)
        ADR_MODE:  mode_d = wr_data_i;
        ADR_MUX:   mux_d  = wr_data_i;
        ADR_RESET: rst_d  = wr_data_i;
        default:   ;
      endcase
    end
    req_d = (rst_d == DATA_W'(1));
  end

  always_comb begin
    case (addr_i)
      ADR_MODE:    rd_data_o = mode_q;
      ADR_MUX:     rd_data_o = mux_q;
      ADR_DIP:     rd_data_o = {{(DATA_W-DIP_W){1'b0}}, dip_i};
      ADR_RESET:   rd_data_o = rst_q;
      ADR_VERSION: rd_data_o = VERSION;
      default:     rd_data_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      mux_q  <= '0;
      rst_q  <= '0;
      req_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      mux_q  <= mux_d;
      rst_q  <= rst_d;
      req_q  <= req_d;
    end
  end

  assign mode_o    = mode_q;
  assign mux_o     = mux_q;
  assign rst_req_o = req_q;

  // R6: mode and mux registers change only after a write to their own address
  assert_mode_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(wr_en_i && addr_i == ADR_MODE));
  assert_mux_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mux_q) |-> $past(wr_en_i && addr_i == ADR_MUX));

  // R5: the request rises only after writing 1 to the reset register
  assert_req_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> $past(wr_en_i && addr_i == ADR_RESET && wr_data_i == DATA_W'(1)));
endmodule

// File: rtl/ssr_slave.sv
module ssr_slave
  import ssr_pkg::*;
#(
  parameter int                DIP_W   = 8,
  parameter logic [DATA_W-1:0] VERSION = 32'h0000_0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_sck_i,
  input  logic              ser_sdi_i,
  input  logic              ser_stb_n_i,
  output logic              ser_sdo_o,
  input  logic [DIP_W-1:0]  dip_i,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] mux_o,
  output logic              sys_rst_req_o
);
  logic [2:0]        sync_q;
  logic              wr_en;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  ssr_sync #(.W(3), .RST_VAL(3'b100)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({ser_stb_n_i, ser_sdi_i, ser_sck_i}),
    .q_o   (sync_q)
  );

  ssr_frame i_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_i     (sync_q[0]),
    .sdi_i     (sync_q[1]),
    .stb_n_i   (sync_q[2]),
    .rd_data_i (rd_data),
    .wr_en_o   (wr_en),
    .addr_o    (addr),
    .wr_data_o (wr_data),
    .sdo_o     (ser_sdo_o)
  );

  ssr_regs #(.DIP_W(DIP_W), .VERSION(VERSION)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wr_data_i (wr_data),
    .dip_i     (dip_i),
    .rd_data_o (rd_data),
    .mode_o    (mode_o),
    .mux_o     (mux_o),
    .rst_req_o (sys_rst_req_o)
  );
endmodule

// File: tb/test_ssr_slave.sv
module test_ssr_slave;
  localparam int H = 6;
  localparam logic [31:0] VER = 32'h0000_0101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, sdi = 1'b0, stb_n = 1'b1;
  logic sdo, req;
  logic [7:0] dip = 8'h00;
  logic [31:0] mode, mux;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_mode = 0, m_mux = 0, m_rst = 0;

  always #2.5 clk = ~clk;

  ssr_slave #(.DIP_W(8), .VERSION(VER)) i_ssr_slave (
    .clk(clk), .rst_n(rst_n), .ser_sck_i(sck), .ser_sdi_i(sdi),
    .ser_stb_n_i(stb_n), .ser_sdo_o(sdo), .dip_i(dip),
    .mode_o(mode), .mux_o(mux), .sys_rst_req_o(req)
  );

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00: return m_mode;
      8'h02: return m_mux;
      8'h08: return {24'h0, dip};
      8'h80: return m_rst;
      8'hFF: return VER;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b, input logic strobe);
    @(negedge clk);
    sdi = b;
    if (strobe) stb_n = 1'b0;
    wait_n(H); sck = 1'b1;
    wait_n(H); sck = 1'b0;
    wait_n(H); stb_n = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    for (int i = 31; i >= 0; i--) pulse(d[i], 1'b0);
    for (int i = 7; i >= 0; i--) pulse(a[i], 1'b0);
    pulse(1'b1, 1'b1);
    wait_n(H);
    case (a)
      8'h00: m_mode = d;
      8'h02: m_mux = d;
      8'h80: m_rst = d;
      default: ;
    endcase
  endtask

  task automatic do_read(input logic [7:0] a, input string r);
    logic [31:0] v, e;
    e = exp_read(a);
    for (int i = 7; i >= 0; i--) pulse(a[i], 1'b0);
    pulse(1'b0, 1'b1);
    chk("R3 msb before first rise", {31'h0, sdo}, {31'h0, e[31]});
    for (int i = 31; i >= 0; i--) begin
      @(negedge clk); sck = 1'b1;
      wait_n(H); v[i] = sdo; sck = 1'b0;
      wait_n(H);
    end
    wait_n(H);
    chk(r, v, e);
    chk("R8 line released after read", {31'h0, sdo}, 32'h1);
  endtask

  task automatic chk_outs(input string r);
    chk(r, mode, m_mode);
    chk(r, mux, m_mux);
    chk(r, {31'h0, req}, {31'h0, m_rst == 32'h1});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] a;
    logic [31:0] d;
    logic [7:0] addrs [5] = '{8'h00, 8'h02, 8'h08, 8'h80, 8'hFF};
    void'($urandom(32'h5EED_1234));
    wait_n(5);
    // R9 reset state
    chk("R9 reset mode", mode, 0);
    chk("R9 reset mux", mux, 0);
    chk("R9 reset req/sdo", {30'h0, req, sdo}, 32'h1);
    rst_n = 1'b1;
    wait_n(4);
    chk("R8 idle line", {31'h0, sdo}, 32'h1);

    // R1, R2 directed
    do_write(8'h00, 32'hA5C3_0F81); chk_outs("R1 mode write");
    do_read(8'h00, "R1 mode readback");
    do_write(8'h02, 32'h8000_0001); chk_outs("R2 mux write");
    do_read(8'h02, "R2 mux readback");
    // R4
    dip = 8'hB6;
    do_read(8'h08, "R4 dip read");
    do_read(8'hFF, "R4 version read");
    // R5
    do_write(8'h80, 32'h1); chk_outs("R5 request set");
    do_read(8'h80, "R5 reset readback");
    do_write(8'h80, 32'h3); chk_outs("R5 value 3 no request");
    do_write(8'h80, 32'h1); do_write(8'h80, 32'h0); chk_outs("R5 request cleared");
    // R6 ignored writes
    do_write(8'h08, 32'hFFFF_FFFF); do_write(8'hFF, 32'h1234_5678);
    do_write(8'h01, 32'hDEAD_BEEF); do_write(8'h81, 32'h1);
    chk_outs("R6 ignored writes outputs");
    do_read(8'h80, "R6 reset unchanged");
    do_read(8'hFF, "R6 version unchanged");
    do_read(8'h08, "R6 dip unchanged");
    // R7
    do_read(8'h01, "R7 unmapped read 01");
    do_read(8'h7F, "R7 unmapped read 7F");
    // R10 leading junk bits
    for (int i = 0; i < 13; i++) pulse(logic'(i % 2), 1'b0);
    do_write(8'h02, 32'h0123_4567); chk_outs("R10 junk prefix write");
    for (int i = 0; i < 9; i++) pulse(1'b1, 1'b0);
    do_read(8'h02, "R10 junk prefix read");

    // random mix
    for (int n = 0; n < 40; n++) begin
      a = ($urandom % 4 == 0) ? 8'($urandom) : addrs[$urandom % 5];
      d = ($urandom % 3 == 0) ? 32'h1 : $urandom;
      dip = 8'($urandom);
      if ($urandom % 2) begin
        do_write(a, d);
        chk_outs("R1 R2 R5 R6 random write");
      end else begin
        do_read(a, "R3 R4 R7 random read");
      end
    end

    // R9 reset mid-run
    do_write(8'h80, 32'h1);
    do_write(8'h00, 32'hFFFF_0000);
    @(negedge clk); rst_n = 1'b0;
    m_mode = 0; m_mux = 0; m_rst = 0;
    wait_n(3);
    chk_outs("R9 reset clears registers");
    chk("R9 reset line idle", {31'h0, sdo}, 32'h1);
    @(negedge clk); rst_n = 1'b1;
    wait_n(4);
    do_read(8'h00, "R9 mode after reset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule